// File: doc/BRIEF.md
# Strobe-Bus Target Register File

This block sits inside a peripheral device on the target end of a multiplexed 8-bit parallel bus. The master frames each access with an active-low select, marks the direction with a write flag and moves one byte per strobe pulse. A separate address-latch flag marks the byte that carries the register address. A 16-bit register value then moves as two data bytes, high byte first.

Every bus input is asynchronous to the local clock. Each one passes through a two-stage synchronizer, and strobe and select edges are detected locally. Behind the bus logic sits a register file of 16 entries by 16 bits. A write is committed once its second data byte has arrived. A read serves the high byte and then the low byte of the addressed entry on the shared data lines, and the output enable is raised only while the target owns the lines.

At each rising edge of select the target reports a pending flag. When the flag is 1, the access is not finished. If a read ends with the flag set, the master repeats the two data bytes without a new address, and the target starts again at the high byte. If a write ends with the flag set, the master pulses select until the flag clears. User logic can hold the flag at 1 through a busy input.

Top module: `sbt_target_regs`

## Requirements
- R1: A strobe rising edge with select low and the address-latch flag high takes the 8-bit data byte as the register address, and the next data byte is treated as the high byte.
- R2: With the write flag at 1 and the address-latch flag low, the first data strobe after an address supplies bits 15:8 and the second supplies bits 7:0. The 16-bit word is stored in the addressed entry on the second strobe.
- R3: With the write flag at 0, the target presents bits 15:8 of the addressed entry during the first data strobe and bits 7:0 during the second, with word bit 8+i or bit i on data line i. It moves to the next byte when the strobe falls.
- R4: The data output enable is 1 only when the synchronized write flag is 0, select is low, the address-latch flag is low and a read byte is armed. It is 0 during address phases and during writes.
- R5: Address values 0 to 15 select entries 0 to 15. A write to an address of 16 or more is discarded and does not alias onto a low entry, and a read of such an address returns 0x0000.
- R6: On each rising edge of select, the pending output is set to 1 if the busy input is high or if both data bytes have not completed since the last address phase, and to 0 otherwise. It is valid no later than 4 clock cycles after select rises at the pin and holds between select rising edges.
- R7: After the low byte of a read, the target wraps back to the high byte of the same entry, so two more data strobes without an address phase return the same word.
- R8: Strobe edges while select is high have no effect on the address, the byte phase or the register contents.
- R9: Synchronous active-high reset clears the pending flag, the output enable, the output data byte and the byte phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel_n | input | 1 | Active-low select from the master, asynchronous |
| bus_wr | input | 1 | Direction flag: 1 write, 0 read, asynchronous |
| bus_stb | input | 1 | Byte strobe, active on the rising edge, asynchronous |
| bus_alat | input | 1 | Address-latch flag marking an address byte, asynchronous |
| bus_dat_i | input | 8 | Data lines as seen from the bus |
| bus_dat_o | output | 8 | Read byte driven toward the bus |
| bus_dat_oe | output | 1 | Output enable for the data lines |
| bus_pend | output | 1 | Pending flag: 1 means the access is not finished |
| user_busy | input | 1 | Local busy request that keeps the pending flag at 1 |

## Verification
A wrong byte phase shows up at the data pins within one strobe. The high and low halves come out swapped or shifted, or a retried read begins at the low byte. A missing phase reset after an address shows the same swap on the next transaction. A wrong address decode shows up only on a later read-back, which returns a value stored at an aliased entry. A wrong completion flag shows on the pending output a few cycles after select rises, so it is checked after every transaction, including deliberately incomplete ones.

// File: rtl/sbt_pkg.sv
package sbt_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 2 * BYTE_W;

  // byte pointer of the data phase
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_HI   = 2'd1,
    PH_LO   = 2'd2
  } phase_e;
endpackage

// File: rtl/sbt_sync.sv
module sbt_sync #(
  parameter int             W       = 1,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) st[0] <= RST_VAL;
        else     st[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) st[i] <= RST_VAL;
        else     st[i] <= st[i-1];
      end
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/sbt_ctrl.sv
module sbt_ctrl
  import sbt_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              s_stb,
  input  logic              s_sel_n,
  input  logic              s_wr,
  input  logic              s_alat,
  input  logic [BYTE_W-1:0] s_dat,
  input  logic              user_busy,
  output phase_e            phase,
  output logic [BYTE_W-1:0] addr,
  output logic              we,
  output logic [WORD_W-1:0] wdata,
  output logic              pend,
  output logic              stb_rise,
  output logic              sel_rise
);
  logic              stb_d, sel_d;
  logic              done;     // both data bytes seen since the address
  logic              rd_armed; // last accepted rise was a read data byte
  logic [BYTE_W-1:0] hold_hi;
  logic              stb_fall;

  assign stb_rise = s_stb & ~stb_d & ~s_sel_n;
  assign stb_fall = ~s_stb & stb_d;
  assign sel_rise = s_sel_n & ~sel_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      stb_d    <= 1'b0;
      sel_d    <= 1'b1;
      phase    <= PH_IDLE;
      done     <= 1'b0;
      rd_armed <= 1'b0;
      addr     <= '0;
      hold_hi  <= '0;
      we       <= 1'b0;
      wdata    <= '0;
      pend     <= 1'b0;
    end else begin
      stb_d <= s_stb;
      sel_d <= s_sel_n;
      we    <= 1'b0;
      if (stb_rise) begin
        if (s_alat) begin
          addr     <= s_dat;
          phase    <= PH_HI;
          done     <= 1'b0;
          rd_armed <= 1'b0;
        end else if (s_wr) begin
          rd_armed <= 1'b0;
          if (phase == PH_HI) begin
            hold_hi <= s_dat;
            phase   <= PH_LO;
          end else if (phase == PH_LO) begin
            we    <= 1'b1;
            wdata <= {hold_hi, s_dat};
            phase <= PH_IDLE;
            done  <= 1'b1;
          end
        end else if (phase != PH_IDLE) begin
          rd_armed <= 1'b1;
          if (phase == PH_LO) done <= 1'b1;
        end
      end else if (stb_fall && rd_armed) begin
        rd_armed <= 1'b0;
        // low byte wraps to high byte so a retry restarts the word
        phase    <= (phase == PH_HI) ? PH_LO : PH_HI;
      end
      if (sel_rise) pend <= user_busy | ~done;
    end
  end
endmodule

// File: rtl/sbt_regfile.sv
module sbt_regfile #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 16,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int IDX_W = $clog2(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] rd_raw;
  logic              rng_q;
  logic [IDX_W-1:0]  idx;
  logic              in_rng;

  assign idx    = addr[IDX_W-1:0];
  assign in_rng = (addr >> IDX_W) == '0;

  always_ff @(posedge clk) begin
    if (we && in_rng) mem[idx] <= wdata;
    rd_raw <= mem[idx];
    rng_q  <= in_rng;
  end

  assign rdata = rng_q ? rd_raw : '0;
endmodule

// File: rtl/sbt_target_regs.sv
module sbt_target_regs
  import sbt_pkg::*;
#(
  parameter int DEPTH       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel_n,
  input  logic              bus_wr,
  input  logic              bus_stb,
  input  logic              bus_alat,
  input  logic [BYTE_W-1:0] bus_dat_i,
  output logic [BYTE_W-1:0] bus_dat_o,
  output logic              bus_dat_oe,
  output logic              bus_pend,
  input  logic              user_busy
);
  localparam int SYN_W = BYTE_W + 4;
  localparam logic [SYN_W-1:0] SYN_RST = {1'b1, {(SYN_W-1){1'b0}}};

  logic [SYN_W-1:0]  syn_q;
  logic              s_sel_n, s_wr, s_stb, s_alat;
  logic [BYTE_W-1:0] s_dat;
  phase_e            phase;
  logic [BYTE_W-1:0] addr;
  logic              mem_we;
  logic [WORD_W-1:0] wdata, rdata;
  logic              stb_rise, sel_rise;

  sbt_sync #(.W(SYN_W), .STAGES(SYNC_STAGES), .RST_VAL(SYN_RST)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({bus_sel_n, bus_wr, bus_stb, bus_alat, bus_dat_i}),
    .q   (syn_q)
  );
  assign {s_sel_n, s_wr, s_stb, s_alat, s_dat} = syn_q;

  sbt_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .s_stb     (s_stb),
    .s_sel_n   (s_sel_n),
    .s_wr      (s_wr),
    .s_alat    (s_alat),
    .s_dat     (s_dat),
    .user_busy (user_busy),
    .phase     (phase),
    .addr      (addr),
    .we        (mem_we),
    .wdata     (wdata),
    .pend      (bus_pend),
    .stb_rise  (stb_rise),
    .sel_rise  (sel_rise)
  );

  sbt_regfile #(.DEPTH(DEPTH), .DATA_W(WORD_W), .ADDR_W(BYTE_W)) u_rf (
    .clk   (clk),
    .addr  (addr),
    .we    (mem_we),
    .wdata (wdata),
    .rdata (rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_dat_o  <= '0;
      bus_dat_oe <= 1'b0;
    end else begin
      bus_dat_o  <= (phase == PH_LO) ? rdata[BYTE_W-1:0] : rdata[WORD_W-1:BYTE_W];
      bus_dat_oe <= ~s_wr & ~s_sel_n & ~s_alat & (phase != PH_IDLE);
    end
  end
endmodule

// File: rtl/sbt_target_chk.sv
module sbt_target_chk (
  input logic clk,
  input logic rst,
  input logic s_wr,
  input logic s_sel_n,
  input logic s_alat,
  input logic stb_rise,
  input logic sel_rise,
  input logic mem_we,
  input logic user_busy,
  input logic bus_dat_oe,
  input logic bus_pend
);
  p_oe_gate_r4: assert property (@(posedge clk) disable iff (rst)
    bus_dat_oe |-> $past(!s_wr && !s_sel_n && !s_alat));

  p_rst_quiet_r9: assert property (@(posedge clk)
    $past(rst) |-> (!bus_dat_oe && !bus_pend));

  p_pend_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !sel_rise |=> $stable(bus_pend));

  p_busy_pend_r6: assert property (@(posedge clk) disable iff (rst)
    (sel_rise && user_busy) |=> bus_pend);

  p_we_write_r2: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> $past(stb_rise && s_wr && !s_alat));

  p_we_sel_r8: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> $past(!s_sel_n));
endmodule

bind sbt_target_regs sbt_target_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .s_wr       (s_wr),
  .s_sel_n    (s_sel_n),
  .s_alat     (s_alat),
  .stb_rise   (stb_rise),
  .sel_rise   (sel_rise),
  .mem_we     (mem_we),
  .user_busy  (user_busy),
  .bus_dat_oe (bus_dat_oe),
  .bus_pend   (bus_pend)
);

// File: tb/sbt_target_regs_tb.sv
module sbt_target_regs_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;
  // {address, value}: in-range, overwrite, out-of-range, alias of entry 0
  localparam logic [23:0] VEC [NVEC] = '{
    {8'h00, 16'hA55A}, {8'h01, 16'h1234}, {8'h0F, 16'hFFFF}, {8'h07, 16'h8001},
    {8'h01, 16'hBEEF}, {8'h9C, 16'h5555}, {8'h10, 16'h7777}, {8'h0A, 16'h0000}
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_sel_n = 1'b1, bus_wr = 1'b0, bus_stb = 1'b0, bus_alat = 1'b0;
  logic [7:0] bus_dat_i = 8'h00;
  logic [7:0] bus_dat_o;
  logic       bus_dat_oe, bus_pend;
  logic       user_busy = 1'b0;

  int checks = 0, failures = 0;
  bit finished = 1'b0;
  logic [15:0] model [16];

  always #(CLK_PERIOD/2) clk = ~clk;

  sbt_target_regs u_dut (
    .clk(clk), .rst(rst), .bus_sel_n(bus_sel_n), .bus_wr(bus_wr), .bus_stb(bus_stb),
    .bus_alat(bus_alat), .bus_dat_i(bus_dat_i), .bus_dat_o(bus_dat_o),
    .bus_dat_oe(bus_dat_oe), .bus_pend(bus_pend), .user_busy(user_busy)
  );

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic addr_phase(input logic [7:0] a);
    bus_sel_n = 0; bus_alat = 1; bus_dat_i = a; wt(4);
    bus_stb = 1; wt(4);
    bus_stb = 0; bus_alat = 0; bus_dat_i = 0; wt(6);
  endtask

  task automatic wr_txn(input logic [7:0] a, input logic [15:0] v, output bit p, output bit oe_seen);
    oe_seen = 0;
    bus_wr = 1; addr_phase(a);
    for (int k = 0; k < 2; k++) begin
      bus_dat_i = (k == 0) ? v[15:8] : v[7:0]; wt(4);
      bus_stb = 1; wt(4);
      oe_seen |= bus_dat_oe;
      if (k == 0) begin bus_stb = 0; bus_dat_i = 0; wt(4); end
    end
    bus_sel_n = 1; wt(6); p = bus_pend;
    bus_stb = 0; bus_dat_i = 0; wt(4);
  endtask

  task automatic rd_txn(input logic [7:0] a, input bit with_addr, output logic [15:0] v,
                        output bit p, output bit oe_ok);
    oe_ok = 1;
    bus_wr = 0;
    if (with_addr) addr_phase(a);
    else begin bus_sel_n = 0; bus_stb = 0; wt(6); end
    for (int k = 0; k < 2; k++) begin
      bus_stb = 1; wt(4);
      oe_ok &= bus_dat_oe;
      if (k == 0) begin v[15:8] = bus_dat_o; bus_stb = 0; wt(6); end
      else v[7:0] = bus_dat_o;
    end
    bus_sel_n = 1; wt(6); p = bus_pend;
    bus_stb = 0; wt(4);
  endtask

  task automatic sel_pulse(output bit p);
    bus_sel_n = 0; wt(4);
    bus_sel_n = 1; wt(6); p = bus_pend;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++; checks++;
      $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [15:0] v, exp;
    bit p, oe;
    wt(5); rst = 0; wt(2);
    // R9: reset state
    chk(bus_dat_oe == 0, "R9 oe after reset", 16'(bus_dat_oe), 16'h0);
    chk(bus_pend == 0, "R9 pend after reset", 16'(bus_pend), 16'h0);
    chk(bus_dat_o == 0, "R9 data after reset", 16'(bus_dat_o), 16'h0);

    // R1 R2 R4 R5: vector table, writes then read-back
    for (int i = 0; i < NVEC; i++) begin
      wr_txn(VEC[i][23:16], VEC[i][15:0], p, oe);
      if (VEC[i][23:16] < 16) model[VEC[i][19:16]] = VEC[i][15:0];
      chk(p == 0, "R6 write complete pend", 16'(p), 16'h0);
      chk(oe == 0, "R4 oe off during write", 16'(oe), 16'h0);
    end
    for (int i = 0; i < NVEC; i++) begin
      rd_txn(VEC[i][23:16], 1'b1, v, p, oe);
      exp = (VEC[i][23:16] < 16) ? model[VEC[i][19:16]] : 16'h0000;
      chk(v == exp, "R2 R3 R5 read-back", v, exp);
      chk(oe == 1, "R4 oe on in read data", 16'(oe), 16'h1);
    end

    // R6 R7: read with busy, then retry without address
    user_busy = 1;
    rd_txn(8'h07, 1'b1, v, p, oe);
    chk(p == 1, "R6 busy read pend", 16'(p), 16'h1);
    user_busy = 0;
    rd_txn(8'h00, 1'b0, v, p, oe);
    chk(v == 16'h8001, "R7 retry restarts high byte", v, 16'h8001);
    chk(p == 0, "R6 retry pend clear", 16'(p), 16'h0);

    // R6: busy write completion loop
    user_busy = 1;
    wr_txn(8'h03, 16'hC3A5, p, oe);
    chk(p == 1, "R6 busy write pend", 16'(p), 16'h1);
    sel_pulse(p);
    chk(p == 1, "R6 pend held while busy", 16'(p), 16'h1);
    user_busy = 0;
    sel_pulse(p);
    chk(p == 0, "R6 pend clears on select edge", 16'(p), 16'h0);
    rd_txn(8'h03, 1'b1, v, p, oe);
    chk(v == 16'hC3A5, "R2 write committed under busy", v, 16'hC3A5);

    // R6: incomplete read (one byte) reports pending
    bus_wr = 0; addr_phase(8'h01);
    bus_stb = 1; wt(4);
    bus_sel_n = 1; wt(6);
    chk(bus_pend == 1, "R6 incomplete access pend", 16'(bus_pend), 16'h1);
    bus_stb = 0; wt(4);

    // R4: oe off during read address phase
    bus_wr = 0; bus_sel_n = 0; bus_alat = 1; bus_dat_i = 8'h01; wt(6);
    chk(bus_dat_oe == 0, "R4 oe off in address phase", 16'(bus_dat_oe), 16'h0);
    bus_alat = 0; bus_dat_i = 0; bus_sel_n = 1; wt(4);

    // R8: full write sequence with select held high is ignored
    bus_wr = 1; bus_sel_n = 1;
    bus_alat = 1; bus_dat_i = 8'h0F; wt(4); bus_stb = 1; wt(4); bus_stb = 0; bus_alat = 0; wt(4);
    bus_dat_i = 8'h11; wt(4); bus_stb = 1; wt(4); bus_stb = 0; wt(4);
    bus_dat_i = 8'h22; wt(4); bus_stb = 1; wt(4); bus_stb = 0; bus_dat_i = 0; wt(4);
    rd_txn(8'h0F, 1'b1, v, p, oe);
    chk(v == model[15], "R8 strobes with select high ignored", v, model[15]);

    // R1: new address resets byte phase after partial write
    bus_wr = 1; addr_phase(8'h05);
    bus_dat_i = 8'h99; wt(4); bus_stb = 1; wt(4); bus_stb = 0; bus_dat_i = 0; wt(4);
    wr_txn(8'h05, 16'h1357, p, oe);
    rd_txn(8'h05, 1'b1, v, p, oe);
    chk(v == 16'h1357, "R1 address restarts high byte", v, 16'h1357);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule